// File: doc/BRIEF.md
# Cycle-Stealing DMA Channel

A single DMA channel that copies one byte or one 16-bit word per accepted request from a source address to a destination address on a 20-bit memory bus. Each transfer is a read at the source followed by a write of the same data to the destination. While the channel has work, it holds the shared bus and withholds the grant from the CPU. Software programs four registers through a plain write port: source pointer, destination pointer, transfer counter and a control word.

A run is programmed by loading the counter with one less than the number of transfers wanted. After every write, the counter steps down, and each pointer moves on if its direction bit is set. The transfer that finds the counter at zero is the last one of the run, and the counter wraps. In single mode the channel then turns itself off. In repeat mode the source pointer, the counter and (when it moves forward) the destination pointer return to the values software last wrote, and the channel stays on.

The memory side is valid/ready. While `mem_valid` is high and `mem_ready` is low, the channel holds `mem_addr`, `mem_write`, `mem_byte` and `mem_wdata` steady. A beat completes on a cycle with both high. The request input `trig` is a plain one-cycle pulse, and the status outputs are plain levels.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, all status outputs are zero, `mem_valid` is low and `cpu_gnt` follows `cpu_req`.
- R2: A `trig` pulse while enabled sets the request flag (control bit 2). The channel then issues a read at the source pointer. After that read completes, it issues a write of the same data at the destination pointer: one transfer per request.
- R3: Control bit 0 selects the unit: 1 moves a byte (`mem_byte` high, data in bits 7:0, step 1), 0 moves a little-endian word (step 2).
- R4: Control bits 4 (source) and 5 (destination) choose the pointer behaviour: 0 holds the pointer, 1 advances it by the step when a write completes.
- R5: The counter (select 2) drops by one after each transfer. A run loaded with N performs N+1 transfers. The transfer done at zero underflows the counter, which wraps to all ones.
- R6: In single mode (control bit 1 = 0), an underflow clears the enable bit (control bit 3) and drops any pending request. While disabled, `trig` is ignored: the flag and the pointers do not change and the bus stays idle.
- R7: In repeat mode (control bit 1 = 1), an underflow reloads the source pointer and the counter from their last written values. The destination pointer is reloaded only when its direction bit is 1. Enable stays set.
- R8: Writing the control word (select 3) with bit 2 = 0 clears the request flag and any queued request. Writing it with bit 2 = 1 never sets the flag.
- R9: The flag clears when the write completes. A `trig` that arrives while a transfer is starting or running is kept, and starts the next transfer straight after.
- R10: While a transfer is running or an enabled request is pending, `cpu_gnt` is low. A beat that `mem_ready` holds off keeps its address, direction and data.
- R11: Writing the source (select 0), destination (select 1) or counter (select 2) also loads the value that the repeat reload uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 counter, 3 control |
| cfg_wdata | input | 20 | Write data (counter takes bits 15:0, control bits 5:0) |
| trig | input | 1 | Transfer request pulse |
| cpu_req | input | 1 | CPU asks for the bus |
| cpu_gnt | output | 1 | CPU owns the bus |
| mem_valid | output | 1 | Memory beat offered |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_write | output | 1 | 1 write, 0 read |
| mem_byte | output | 1 | 1 byte beat, 0 word beat |
| mem_addr | output | 20 | Beat address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, sampled on a read handshake |
| st_src | output | 20 | Current source pointer |
| st_dst | output | 20 | Current destination pointer |
| st_cnt | output | 16 | Current counter |
| st_ctrl | output | 6 | Control word: 0 byte, 1 repeat, 2 request, 3 enable, 4 src forward, 5 dst forward |

## Verification
A `trig` sampled at one edge shows in the request flag and drops `cpu_gnt` in the cycle after. The read beat is offered one cycle after that. The write beat follows in the cycle after the read handshake. The pointers, the counter, the enable bit and the flag change at the edge that completes the write. A register write takes effect at the edge that samples the strobe. The bench's reference model steps at every rising edge with those same latencies, and all outputs are compared with it on every falling edge, so each result is checked in the cycle it falls due, stalled beats included.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;

  localparam int SEL_SRC  = 0;
  localparam int SEL_DST  = 1;
  localparam int SEL_CNT  = 2;
  localparam int SEL_CTRL = 3;

  localparam int CB_BYTE = 0;
  localparam int CB_RPT  = 1;
  localparam int CB_REQ  = 2;
  localparam int CB_EN   = 3;
  localparam int CB_SFWD = 4;
  localparam int CB_DFWD = 5;
  localparam int CTRL_W  = 6;

endpackage

// File: rtl/dma_ptr.sv
module dma_ptr #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_val,
  input  logic          adv,
  input  logic [AW-1:0] step,
  input  logic          reload,
  output logic [AW-1:0] ptr
);

  logic [AW-1:0] init_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      init_q <= '0;
    end else if (wr_en) begin
      ptr    <= wr_val;
      init_q <= wr_val;
    end else if (reload) begin
      ptr <= init_q;
    end else if (adv) begin
      ptr <= ptr + step;
    end
  end

endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_chan_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          trig,
  input  logic          busy,
  input  logic          xfer_done,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output logic          unit_byte,
  output logic          rpt,
  output logic          en,
  output logic          req,
  output logic          sfwd,
  output logic          dfwd
);

  localparam int NPTR = 2;

  logic [CW-1:0]   cnt_init;
  logic            again;
  logic            ctrl_wr;
  logic            underflow;
  logic [AW-1:0]   step;
  logic [AW-1:0]   ptr_q [NPTR];

  assign ctrl_wr   = cfg_we && (cfg_sel == 2'(SEL_CTRL));
  assign underflow = xfer_done && (cnt == '0);
  assign step      = {{(AW-2){1'b0}}, ~unit_byte, unit_byte};

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic fwd;
    logic rl_ok;
    assign fwd   = (g == 0) ? sfwd : dfwd;
    assign rl_ok = (g == 0) ? 1'b1 : dfwd;
    dma_ptr #(.AW(AW)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we && (cfg_sel == 2'((g == 0) ? SEL_SRC : SEL_DST))),
      .wr_val (cfg_wdata),
      .adv    (xfer_done && fwd),
      .step   (step),
      .reload (underflow && rpt && rl_ok),
      .ptr    (ptr_q[g])
    );
  end

  assign src = ptr_q[0];
  assign dst = ptr_q[1];

  // counter and its reload value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      cnt_init <= '0;
    end else if (cfg_we && (cfg_sel == 2'(SEL_CNT))) begin
      cnt      <= cfg_wdata[CW-1:0];
      cnt_init <= cfg_wdata[CW-1:0];
    end else if (xfer_done) begin
      if (underflow && rpt) cnt <= cnt_init;
      else                  cnt <= cnt - 1'b1;
    end
  end

  // mode bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_byte <= 1'b0;
      rpt       <= 1'b0;
      en        <= 1'b0;
      sfwd      <= 1'b0;
      dfwd      <= 1'b0;
    end else if (ctrl_wr) begin
      unit_byte <= cfg_wdata[CB_BYTE];
      rpt       <= cfg_wdata[CB_RPT];
      en        <= cfg_wdata[CB_EN];
      sfwd      <= cfg_wdata[CB_SFWD];
      dfwd      <= cfg_wdata[CB_DFWD];
    end else if (underflow && !rpt) begin
      en <= 1'b0;
    end
  end

  // request flag and one queued request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req   <= 1'b0;
      again <= 1'b0;
    end else if (ctrl_wr && !cfg_wdata[CB_REQ]) begin
      req   <= 1'b0;
      again <= 1'b0;
    end else if (xfer_done) begin
      req   <= (underflow && !rpt) ? 1'b0 : (again | (trig & en));
      again <= 1'b0;
    end else if (trig && en) begin
      if (busy) again <= 1'b1;
      else      req   <= 1'b1;
    end
  end

  // R6
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && !rpt && !cfg_we |=> !en && !req);

  // R6
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !req && !cfg_we |=> !req);

  // R7
  repeat_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && rpt && !cfg_we |=> (cnt == $past(cnt_init)) && en);

  // R8
  no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && cfg_wdata[CB_REQ] && !req && !xfer_done && !(trig && en) |=> !req);

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !again && !trig && !cfg_we |=> !req);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_chan_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          unit_byte,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_valid,
  output logic          mem_write,
  output logic          mem_byte,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          xfer_done
);

  phase_e        ph;
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      hold_q <= '0;
    end else begin
      unique case (ph)
        PH_IDLE:  if (go) ph <= PH_READ;
        PH_READ:  if (mem_ready) begin
                    hold_q <= unit_byte ? {{(DW-8){1'b0}}, mem_rdata[7:0]} : mem_rdata;
                    ph     <= PH_WRITE;
                  end
        PH_WRITE: if (mem_ready) ph <= PH_IDLE;
        default:  ph <= PH_IDLE;
      endcase
    end
  end

  assign mem_valid = (ph != PH_IDLE);
  assign mem_write = (ph == PH_WRITE);
  assign mem_byte  = unit_byte;
  assign mem_addr  = (ph == PH_WRITE) ? dst : src;
  assign mem_wdata = hold_q;
  assign busy      = (ph != PH_IDLE) || go;
  assign xfer_done = (ph == PH_WRITE) && mem_ready;

  // R10
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write)
                                && $stable(mem_wdata));

  // R2
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_write && mem_ready |=> mem_valid && mem_write);

endmodule

// File: rtl/dma_busarb.sv
module dma_busarb (
  input  logic cpu_req,
  input  logic dma_busy,
  output logic cpu_gnt
);

  assign cpu_gnt = cpu_req && !dma_busy;

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [AW-1:0]     cfg_wdata,
  input  logic              trig,
  input  logic              cpu_req,
  output logic              cpu_gnt,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic              mem_byte,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic [AW-1:0]     st_src,
  output logic [AW-1:0]     st_dst,
  output logic [CW-1:0]     st_cnt,
  output logic [CTRL_W-1:0] st_ctrl
);

  logic unit_byte, rpt, en, req, sfwd, dfwd;
  logic busy, xfer_done;

  dma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .trig      (trig),
    .busy      (busy),
    .xfer_done (xfer_done),
    .src       (st_src),
    .dst       (st_dst),
    .cnt       (st_cnt),
    .unit_byte (unit_byte),
    .rpt       (rpt),
    .en        (en),
    .req       (req),
    .sfwd      (sfwd),
    .dfwd      (dfwd)
  );

  dma_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (en && req),
    .unit_byte (unit_byte),
    .src       (st_src),
    .dst       (st_dst),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .mem_byte  (mem_byte),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .xfer_done (xfer_done)
  );

  dma_busarb u_arb (
    .cpu_req  (cpu_req),
    .dma_busy (busy),
    .cpu_gnt  (cpu_gnt)
  );

  always_comb begin
    st_ctrl          = '0;
    st_ctrl[CB_BYTE] = unit_byte;
    st_ctrl[CB_RPT]  = rpt;
    st_ctrl[CB_REQ]  = req;
    st_ctrl[CB_EN]   = en;
    st_ctrl[CB_SFWD] = sfwd;
    st_ctrl[CB_DFWD] = dfwd;
  end

  // R10
  bus_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !cpu_gnt);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> !mem_valid && (st_ctrl == '0));

endmodule

// File: tb/dma_chan_engine_bench.sv
`timescale 1ns/1ps
module dma_chan_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [19:0] cfg_wdata = '0;
  logic        trig = 1'b0;
  logic        cpu_req = 1'b1;
  logic        cpu_gnt;
  logic        mem_valid, mem_ready, mem_write, mem_byte;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [19:0] st_src, st_dst;
  logic [15:0] st_cnt;
  logic [5:0]  st_ctrl;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  logic throttle = 1'b0;
  logic hold_off = 1'b0;

  always #4 clk = ~clk;

  dma_chan_engine u_dma_chan_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .trig(trig), .cpu_req(cpu_req), .cpu_gnt(cpu_gnt), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_byte(mem_byte), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .st_src(st_src), .st_dst(st_dst),
    .st_cnt(st_cnt), .st_ctrl(st_ctrl)
  );

  // memory
  logic [7:0] mem [256];
  assign mem_rdata = mem_byte ? {8'h00, mem[mem_addr[7:0]]}
                              : {mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]};
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (mem_valid && mem_ready && mem_write) begin
      mem[mem_addr[7:0]] <= mem_wdata[7:0];
      if (!mem_byte) mem[mem_addr[7:0] + 8'd1] <= mem_wdata[15:8];
    end
  end

  initial mem_ready = 1'b1;
  always @(negedge clk) begin
    cyc++;
    mem_ready = hold_off ? 1'b0 : (throttle ? ((cyc % 3) != 0) : 1'b1);
  end

  // reference model
  int m_ph;
  logic [19:0] m_src, m_dst, m_si, m_di, m_stp;
  logic [15:0] m_cnt, m_ci, m_data;
  logic m_byte, m_rpt, m_en, m_req, m_again, m_sf, m_df;
  logic m_hs, m_start, m_rd, m_done, m_busy0, m_en0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_src = 0; m_dst = 0; m_si = 0; m_di = 0; m_cnt = 0; m_ci = 0; m_data = 0;
      m_byte = 0; m_rpt = 0; m_en = 0; m_req = 0; m_again = 0; m_sf = 0; m_df = 0;
    end else begin
      m_hs    = (m_ph != 0) && mem_ready;
      m_start = (m_ph == 0) && m_en && m_req;
      m_rd    = (m_ph == 1) && m_hs;
      m_done  = (m_ph == 2) && m_hs;
      m_busy0 = (m_ph != 0) || m_start;
      m_en0   = m_en;
      m_stp   = m_byte ? 20'd1 : 20'd2;
      if (trig && m_en0) begin
        if (m_busy0) m_again = 1; else m_req = 1;
      end
      if (m_rd) m_data = m_byte ? {8'h00, mem[m_src[7:0]]}
                                : {mem[m_src[7:0] + 8'd1], mem[m_src[7:0]]};
      if (m_done) begin
        if (m_sf) m_src = m_src + m_stp;
        if (m_df) m_dst = m_dst + m_stp;
        if (m_cnt == 0) begin
          if (m_rpt) begin
            m_src = m_si; m_cnt = m_ci;
            if (m_df) m_dst = m_di;
            m_req = m_again;
          end else begin
            m_cnt = 16'hFFFF; m_en = 0; m_req = 0;
          end
        end else begin
          m_cnt = m_cnt - 1;
          m_req = m_again;
        end
        m_again = 0;
      end
      if (m_start) m_ph = 1;
      else if (m_rd) m_ph = 2;
      else if (m_done) m_ph = 0;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: begin m_src = cfg_wdata; m_si = cfg_wdata; end
          2'd1: begin m_dst = cfg_wdata; m_di = cfg_wdata; end
          2'd2: begin m_cnt = cfg_wdata[15:0]; m_ci = cfg_wdata[15:0]; end
          default: begin
            m_byte = cfg_wdata[0]; m_rpt = cfg_wdata[1]; m_en = cfg_wdata[3];
            m_sf = cfg_wdata[4]; m_df = cfg_wdata[5];
            if (!cfg_wdata[2]) begin m_req = 0; m_again = 0; end
          end
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 cpu_gnt", 32'(cpu_gnt), 32'(cpu_req && !((m_ph != 0) || (m_en && m_req))));
      chk("R2 mem_valid", 32'(mem_valid), 32'(m_ph != 0));
      if (m_ph != 0) begin
        chk("R4 mem_addr", 32'(mem_addr), 32'((m_ph == 1) ? m_src : m_dst));
        chk("R2 mem_write", 32'(mem_write), 32'(m_ph == 2));
        chk("R3 mem_byte", 32'(mem_byte), 32'(m_byte));
        if (m_ph == 2) chk("R2 mem_wdata", 32'(mem_wdata), 32'(m_data));
      end
      chk("R4 st_src", 32'(st_src), 32'(m_src));
      chk("R4 st_dst", 32'(st_dst), 32'(m_dst));
      chk("R5 st_cnt", 32'(st_cnt), 32'(m_cnt));
      chk("R6 st_ctrl", 32'(st_ctrl), 32'({m_df, m_sf, m_en, m_req, m_rpt, m_byte}));
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [19:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk); trig = 1'b1;
    repeat (n) @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (m_ph == 0 && !(m_en && m_req) && !mem_valid) break;
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", 32'(st_ctrl), 32'h0);
    chk("R1 valid", 32'(mem_valid), 32'h0);
    chk("R1 gnt", 32'(cpu_gnt), 32'h1);
    chk("R1 src", 32'(st_src), 32'h0);

    // R6: trigger while disabled is ignored
    pulse(1); settle();
    chk("R6 ignored", 32'(st_ctrl), 32'h0);

    // single byte run, src forward, dst fixed, three transfers
    wr(2'd0, 20'h00010); wr(2'd1, 20'h00080); wr(2'd2, 20'd2);
    wr(2'd3, 20'h19);
    for (int k = 0; k < 3; k++) begin pulse(1); settle(); end
    chk("R5 underflow cnt", 32'(st_cnt), 32'hFFFF);
    chk("R4 src advanced", 32'(st_src), 32'h13);
    chk("R4 dst fixed", 32'(st_dst), 32'h80);
    chk("R6 enable cleared", 32'(st_ctrl), 32'h11);
    chk("R3 byte copied", 32'(mem[8'h80]), 32'h81);
    pulse(1); settle(); pulse(1); settle();
    chk("R6 no more transfers", 32'(st_src), 32'h13);

    // repeat word run with throttled memory
    throttle = 1'b1;
    wr(2'd0, 20'h00020); wr(2'd1, 20'h00040); wr(2'd2, 20'd1);
    wr(2'd3, 20'h3A);
    pulse(1); settle();
    chk("R3 word step", 32'(st_src), 32'h22);
    chk("R3 word data lo", 32'(mem[8'h40]), 32'h E3);
    pulse(1); settle();
    chk("R7 src reload", 32'(st_src), 32'h20);
    chk("R7 dst reload fwd", 32'(st_dst), 32'h40);
    chk("R7 cnt reload", 32'(st_cnt), 32'h1);
    chk("R7 still enabled", 32'(st_ctrl), 32'h3A);
    chk("R3 word data hi", 32'(mem[8'h43]), 32'hF8);
    pulse(1); settle();
    chk("R7 continues", 32'(st_src), 32'h22);
    throttle = 1'b0;

    // R11 + R7: repeat with fixed destination, shadow from latest writes
    wr(2'd0, 20'h00030); wr(2'd1, 20'h00070); wr(2'd2, 20'd0);
    wr(2'd3, 20'h1A);
    pulse(1); settle();
    chk("R11 src shadow", 32'(st_src), 32'h30);
    chk("R7 dst fixed kept", 32'(st_dst), 32'h70);
    chk("R11 cnt shadow", 32'(st_cnt), 32'h0);

    // R9: back-to-back requests both served
    wr(2'd0, 20'h00050); wr(2'd1, 20'h00090); wr(2'd2, 20'd5);
    wr(2'd3, 20'h39);
    pulse(2); settle();
    chk("R9 two transfers src", 32'(st_src), 32'h52);
    chk("R9 two transfers cnt", 32'(st_cnt), 32'h3);

    // R8: writing 1 to the flag does not set it
    wr(2'd3, 20'h3D); settle();
    chk("R8 no set", 32'(st_ctrl), 32'h39);

    // R8: clearing drops the queued request during a stalled transfer
    hold_off = 1'b1;
    pulse(1); repeat (3) @(negedge clk);
    pulse(1); repeat (2) @(negedge clk);
    chk("R10 held beat", 32'(mem_valid), 32'h1);
    wr(2'd3, 20'h39);
    hold_off = 1'b0;
    settle();
    chk("R8 one transfer", 32'(st_src), 32'h53);
    chk("R8 flag cleared", 32'(st_ctrl), 32'h39);
    chk("R5 count", 32'(st_cnt), 32'h2);

    repeat (4) @(negedge clk);
    summary();
  end

endmodule